// File: doc/BRIEF.md
# Indirect Branch Trace Message Encoder

This block sits in the program-trace path of a processor debug port. It builds one variable-length trace message each time the core leaves its sequential flow by an indirect route. Each retired instruction is reported to the block as a one-cycle event strobe, together with a class code, a special-register group code and the current target address.

When an event counts as indirect flow, the block forms a message. The message holds a transfer code, the number of instructions since the previous message, and the target expressed as the XOR against the last reported target. The count and address fields are trimmed to their significant bits and packed least-significant-first. The message also reports its own total bit length.

When the core runs compressed code, a second message variant is produced. It has a different transfer code and a 6-bit bit-pointer field that locates the instruction inside its word. Pin serialization and queueing of messages are done elsewhere.

Top module: `ibt_msg_encoder`

## Requirements
- R1: A standard message has transfer code 4 in bits [5:0], the trimmed sequence count directly above it, and the trimmed relative address directly above the count.
- R2: With `cmp_mode` high, the transfer code is 59. A 6-bit pointer field sits between the count and the address. Its bits [1:0] are zero and its bits [5:2] hold `cmp_bit_pos` shifted right by one.
- R3: The count and address fields each take the position of their highest set bit plus one as their width, and never fewer than 1 bit; a zero value takes 1 bit.
- R4: `msg_len` equals the sum of the emitted field widths. Every `msg_data` bit at or above `msg_len` is zero. Standard messages span 8 to 37 bits and compressed ones span 14 to 43 bits.
- R5: Class codes 3 (taken branch with a run-time target), 4 (interrupt) and 5 (exception) produce a message.
- R6: Classes 6 (return from interrupt), 7 (instruction synchronize) and 8 (machine-state write) produce a message. Class 9 (special-register write) produces one only when `ev_spr_grp` is 1 (comparator), 2 (instruction control), 3 (exception cause) or 4 (debug enable). Classes 0, 1, 2 and 10 to 15, and class 9 with any other group, produce no message.
- R7: The reported count is the number of events since the last message, including the current one, saturating at 255. The count restarts after each message.
- R8: The relative address is `ev_target` XOR the last reported target. The last reported target is zero after reset and is updated only when a message is emitted.
- R9: `msg_valid` is high for exactly the cycle after each message-producing event strobe, and at no other time.
- R10: During and after reset, `msg_valid`, `msg_data` and `msg_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One retired instruction this cycle |
| ev_class | input | 4 | Instruction class code (see R5, R6) |
| ev_spr_grp | input | 3 | Special-register group for class 9 |
| ev_target | input | 23 | Flow target address |
| cmp_mode | input | 1 | Compressed-code message variant |
| cmp_bit_pos | input | 5 | True starting bit of the instruction in its word |
| msg_valid | output | 1 | Message present this cycle |
| msg_data | output | 43 | Packed message, LSB first |
| msg_len | output | 6 | Number of meaningful message bits |

## Verification
Counter restart and message emission can fall in the same cycle, and so can the update of the last reported target and the XOR formed for the next message. The bench provokes both collisions by driving message-producing events on consecutive cycles. It also drives an indirect event right after a saturating run of plain events. A scoreboard model predicts each message from the requirements alone. The second back-to-back message is judged on its count of 1, on an address relative to the target of the message just before it, and on its arrival cycle.

// File: rtl/ibt_pkg.sv
package ibt_pkg;

    localparam int TC_W = 6;
    localparam logic [TC_W-1:0] TCODE_STD = 6'd4;
    localparam logic [TC_W-1:0] TCODE_CMP = 6'd59;

    typedef enum logic [3:0] {
        CLS_PLAIN      = 4'd0,
        CLS_BR_DIRECT  = 4'd1,
        CLS_BR_NOTTKN  = 4'd2,
        CLS_BR_RUNTIME = 4'd3,
        CLS_INTERRUPT  = 4'd4,
        CLS_EXCEPTION  = 4'd5,
        CLS_RET_INT    = 4'd6,
        CLS_SYNC       = 4'd7,
        CLS_MSR_WRITE  = 4'd8,
        CLS_SPR_WRITE  = 4'd9
    } flow_class_e;

    typedef enum logic [2:0] {
        GRP_OTHER   = 3'd0,
        GRP_COMPARE = 3'd1,
        GRP_ICTRL   = 3'd2,
        GRP_ECAUSE  = 3'd3,
        GRP_DBGEN   = 3'd4
    } spr_group_e;

    typedef struct packed {
        flow_class_e cls;
        logic [2:0]  grp;
    } flow_event_t;

    // Number of significant bits of a value, never less than one.
    function automatic logic [5:0] sig_bits(input logic [31:0] v);
        logic [5:0] n;
        n = 6'd1;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) n = 6'(i + 1);
        end
        return n;
    endfunction

endpackage

// File: rtl/ibt_flow_classifier.sv
module ibt_flow_classifier
    import ibt_pkg::*;
(
    input  flow_event_t ev,
    output logic        indirect
);
    logic spr_tracked;

    always_comb begin
        unique case (ev.grp)
            GRP_COMPARE, GRP_ICTRL, GRP_ECAUSE, GRP_DBGEN: spr_tracked = 1'b1;
            default:                                       spr_tracked = 1'b0;
        endcase
    end

    always_comb begin
        case (ev.cls)
            CLS_BR_RUNTIME,
            CLS_INTERRUPT,
            CLS_EXCEPTION,
            CLS_RET_INT,
            CLS_SYNC,
            CLS_MSR_WRITE:  indirect = 1'b1;
            CLS_SPR_WRITE:  indirect = spr_tracked;
            default:        indirect = 1'b0;
        endcase
    end
endmodule

// File: rtl/ibt_seq_counter.sv
module ibt_seq_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    output logic [CNT_W-1:0] report
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count including the current instruction, held at the ceiling.
    assign report = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= restart ? '0 : report;
        end
    end
endmodule

// File: rtl/ibt_field_packer.sv
module ibt_field_packer
    import ibt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 23,
    parameter int POS_W  = 5,
    parameter int MSG_W  = 43,
    parameter int LEN_W  = 6
) (
    input  logic [CNT_W-1:0]  seq_count,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic              cmp_en,
    input  logic [POS_W-1:0]  bit_pos,
    output logic [MSG_W-1:0]  msg_bits,
    output logic [LEN_W-1:0]  msg_len
);
    localparam int BP_W = POS_W + 1;

    logic [5:0]      cnt_w;
    logic [5:0]      adr_w;
    logic [BP_W-1:0] bp_field;
    int              bp_lsb;
    int              addr_lsb;

    assign cnt_w    = sig_bits(32'(seq_count));
    assign adr_w    = sig_bits(32'(rel_addr));
    // Halved position in the upper bits, two zero bits below.
    assign bp_field = {bit_pos[POS_W-1:1], 2'b00};

    always_comb begin
        bp_lsb   = TC_W + int'(cnt_w);
        addr_lsb = bp_lsb + (cmp_en ? BP_W : 0);
        msg_bits = MSG_W'(cmp_en ? TCODE_CMP : TCODE_STD);
        msg_bits = msg_bits | (MSG_W'(seq_count) << TC_W);
        if (cmp_en) begin
            msg_bits = msg_bits | (MSG_W'(bp_field) << bp_lsb);
        end
        msg_bits = msg_bits | (MSG_W'(rel_addr) << addr_lsb);
        msg_len  = LEN_W'(addr_lsb + int'(adr_w));
    end
endmodule

// File: rtl/ibt_msg_encoder.sv
module ibt_msg_encoder
    import ibt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int ADDR_W  = 23,
    parameter int POS_W   = 5,
    parameter bit HAS_CMP = 1'b1,
    localparam int MSG_W  = ibt_pkg::TC_W + CNT_W + POS_W + 1 + ADDR_W,
    localparam int LEN_W  = $clog2(MSG_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [3:0]        ev_class,
    input  logic [2:0]        ev_spr_grp,
    input  logic [ADDR_W-1:0] ev_target,
    input  logic              cmp_mode,
    input  logic [POS_W-1:0]  cmp_bit_pos,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_data,
    output logic [LEN_W-1:0]  msg_len
);
    flow_event_t       ev;
    logic              is_indirect;
    logic              fire;
    logic              cmp_eff;
    logic [CNT_W-1:0]  seq_report;
    logic [ADDR_W-1:0] last_tgt_q;
    logic [ADDR_W-1:0] rel_addr;
    logic [MSG_W-1:0]  pk_bits;
    logic [LEN_W-1:0]  pk_len;

    assign ev = '{cls: flow_class_e'(ev_class), grp: ev_spr_grp};

    generate
        if (HAS_CMP) begin : g_cmp
            assign cmp_eff = cmp_mode;
        end else begin : g_nocmp
            assign cmp_eff = 1'b0;
        end
    endgenerate

    ibt_flow_classifier u_class (
        .ev       (ev),
        .indirect (is_indirect)
    );

    assign fire = ev_valid & is_indirect;

    ibt_seq_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .step    (ev_valid),
        .restart (is_indirect),
        .report  (seq_report)
    );

    assign rel_addr = ev_target ^ last_tgt_q;

    ibt_field_packer #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .POS_W  (POS_W),
        .MSG_W  (MSG_W),
        .LEN_W  (LEN_W)
    ) u_pack (
        .seq_count (seq_report),
        .rel_addr  (rel_addr),
        .cmp_en    (cmp_eff),
        .bit_pos   (cmp_bit_pos),
        .msg_bits  (pk_bits),
        .msg_len   (pk_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_tgt_q <= '0;
            msg_valid  <= 1'b0;
            msg_data   <= '0;
            msg_len    <= '0;
        end else begin
            msg_valid <= fire;
            if (fire) begin
                last_tgt_q <= ev_target;
                msg_data   <= pk_bits;
                msg_len    <= pk_len;
            end
        end
    end
endmodule

// File: rtl/ibt_msg_encoder_chk.sv
module ibt_msg_encoder_chk #(
    parameter int CNT_W   = 8,
    parameter int ADDR_W  = 23,
    parameter int POS_W   = 5,
    parameter bit HAS_CMP = 1'b1,
    localparam int MSG_W  = ibt_pkg::TC_W + CNT_W + POS_W + 1 + ADDR_W,
    localparam int LEN_W  = $clog2(MSG_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic [3:0]       ev_class,
    input logic             cmp_mode,
    input logic             msg_valid,
    input logic [MSG_W-1:0] msg_data,
    input logic [LEN_W-1:0] msg_len
);
    localparam int STD_MAX = ibt_pkg::TC_W + CNT_W + ADDR_W;

    // R9
    msg_after_event_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(ev_valid));

    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ((msg_data >> msg_len) == '0));

    // R1
    std_len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_data[5:0] == 6'd4) |-> (msg_len >= 8 && 32'(msg_len) <= STD_MAX));

    // R2
    tcode_variant_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_data[5:0] == (($past(cmp_mode) && HAS_CMP) ? 6'd59 : 6'd4)));

    // R2
    cmp_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_data[5:0] == 6'd59) |-> (msg_len >= 14));

    // R6
    plain_no_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_class <= 4'd2) |=> !msg_valid);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!msg_valid && msg_len == '0));
endmodule

bind ibt_msg_encoder ibt_msg_encoder_chk #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .POS_W   (POS_W),
    .HAS_CMP (HAS_CMP)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (ev_valid),
    .ev_class  (ev_class),
    .cmp_mode  (cmp_mode),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .msg_len   (msg_len)
);

// File: tb/ibt_msg_encoder_tb_top.sv
module ibt_msg_encoder_tb_top;
    localparam int AW = 23;
    localparam int MW = 43;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_valid = 1'b0;
    logic [3:0]    ev_class = '0;
    logic [2:0]    ev_spr_grp = '0;
    logic [AW-1:0] ev_target = '0;
    logic          cmp_mode = 1'b0;
    logic [4:0]    cmp_bit_pos = '0;
    logic          msg_valid;
    logic [MW-1:0] msg_data;
    logic [LW-1:0] msg_len;

    ibt_msg_encoder dut_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_class(ev_class),
        .ev_spr_grp(ev_spr_grp), .ev_target(ev_target), .cmp_mode(cmp_mode),
        .cmp_bit_pos(cmp_bit_pos), .msg_valid(msg_valid), .msg_data(msg_data),
        .msg_len(msg_len)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [MW-1:0] d;
        int            len;
        int            cyc;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_checks = 0;
    int            n_fail = 0;
    int            cyc = 0;
    int            m_cnt = 0;
    logic [AW-1:0] m_last = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int wbits(longint v);
        int w = 0;
        if (v == 0) return 1;
        while (v != 0) begin
            w++;
            v = v >> 1;
        end
        return w;
    endfunction

    function automatic bit is_ind(int c, int g);
        if (c >= 3 && c <= 8) return 1'b1;
        if (c == 9 && g >= 1 && g <= 4) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: present one event for one cycle and predict its message.
    task automatic send(int c, int g, logic [AW-1:0] t, bit cm, int pos, string tag);
        exp_t          e;
        int            rep;
        int            cw;
        int            aw;
        logic [AW-1:0] rel;
        ev_valid    = 1'b1;
        ev_class    = 4'(c);
        ev_spr_grp  = 3'(g);
        ev_target   = t;
        cmp_mode    = cm;
        cmp_bit_pos = 5'(pos);
        if (is_ind(c, g)) begin
            rep = (m_cnt + 1 > 255) ? 255 : m_cnt + 1;
            rel = t ^ m_last;
            cw  = wbits(rep);
            aw  = wbits(longint'(rel));
            e.d = cm ? MW'(59) : MW'(4);
            e.d = e.d | (MW'(rep) << 6);
            if (cm) begin
                e.d   = e.d | (MW'((pos >> 1) << 2) << (6 + cw));
                e.len = 6 + cw + 6 + aw;
                e.d   = e.d | (MW'(rel) << (12 + cw));
            end else begin
                e.len = 6 + cw + aw;
                e.d   = e.d | (MW'(rel) << (6 + cw));
            end
            e.cyc = cyc + 1;
            e.tag = tag;
            sb.push_back(e);
            m_cnt  = 0;
            m_last = t;
        end else begin
            m_cnt = (m_cnt + 1 > 255) ? 255 : m_cnt + 1;
        end
        @(negedge clk);
        if (!is_ind(c, g)) chk(msg_valid == 1'b0, "R6", "no message", 64'(msg_valid), 0);
    endtask

    task automatic idle(int n);
        ev_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each produced message with the scoreboard.
    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected message", 64'(msg_data), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(msg_data == e.d, e.tag, "data", 64'(msg_data), 64'(e.d));
                chk(int'(msg_len) == e.len, e.tag, "length", 64'(msg_len), 64'(e.len));
                chk(cyc == e.cyc, "R9", "arrival cycle", 64'(cyc), 64'(e.cyc));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(msg_valid == 1'b0, "R10", "valid in reset", 64'(msg_valid), 0);
        chk(msg_len == '0, "R10", "length in reset", 64'(msg_len), 0);
        chk(msg_data == '0, "R10", "data in reset", 64'(msg_data), 0);
        rst = 1'b0;
        idle(2);

        // R5 interrupt, R1 standard layout
        send(4, 0, 23'h000005, 0, 0, "R5");
        idle(1);
        // R3 trimming: count 4, wide address
        send(0, 0, 23'h0, 0, 0, "R3");
        send(0, 0, 23'h0, 0, 0, "R3");
        send(0, 0, 23'h0, 0, 0, "R3");
        send(3, 0, 23'h400000, 0, 0, "R3");
        idle(1);
        // R8 same target: zero relative address, minimum length (R4)
        send(5, 0, 23'h400000, 0, 0, "R8");
        idle(1);
        // R7 saturation after 300 plain events
        for (int i = 0; i < 300; i++) send(1, 0, 23'h0, 0, 0, "R6");
        send(4, 0, 23'h123456, 0, 0, "R7");
        idle(1);
        // R2 compressed variant with several bit positions
        send(6, 0, 23'h00F0F0, 1, 31, "R2");
        send(7, 0, 23'h00F0F1, 1, 0, "R2");
        send(8, 0, 23'h00F0F1, 1, 6, "R2");
        idle(1);
        // R6 special-register groups
        for (int g = 0; g < 8; g++) send(9, g, 23'(g * 17), 0, 0, "R6");
        for (int c = 10; c < 16; c++) send(c, 0, 23'h3, 0, 0, "R6");
        send(2, 0, 23'h3, 0, 0, "R6");
        idle(1);
        // R4 maximum standard length: saturated count and full address
        for (int i = 0; i < 260; i++) send(0, 0, 23'h0, 0, 0, "R6");
        send(3, 0, m_last ^ 23'h7FFFFF, 0, 0, "R4");
        idle(1);
        // R4 maximum compressed length
        for (int i = 0; i < 260; i++) send(0, 0, 23'h0, 0, 0, "R6");
        send(5, 0, m_last ^ 23'h400001, 1, 17, "R4");
        idle(1);
        // R7 and R8 back to back: restart and target update in the same cycle
        send(4, 0, 23'h0ABCDE, 0, 0, "R7");
        send(5, 0, 23'h0ABC00, 0, 0, "R8");
        send(3, 0, 23'h1ABC00, 1, 9, "R8");
        idle(4);
        chk(sb.size() == 0, "R9", "pending messages", 64'(sb.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule